// File: doc/BRIEF.md
# Uncorrectable-Error Read Retry Unit

This block sits on the read path between a requester and the memory controller's return path. It forwards each read to memory and watches the uncorrectable-error flag that comes back with the data. ECC decoding is done elsewhere, so the block only sees that flag. When a first response is flagged and the retry feature is enabled, the block sends the same read to memory one more time. If mirror mode is on, that second read goes to the mirror copy instead of the primary.

If the retry returns clean data, the requester gets an ordinary completion and never learns that a fault occurred. If the retry is flagged too, or if retry is disabled and the first response is flagged, the block returns the data marked as poisoned. In the same cycle it pulses an escalation output, sets a sticky escalation status bit and records the failing address in an error log. With mirroring on, a read is therefore lost only when the primary and the mirror copy are both bad at the same location.

The unit handles one read at a time. Its request ready signal stays low from acceptance until the completion is returned.

Top module: `ue_read_retry`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, esc_pulse, esc_status, log_valid and log_ovf are all 0.
- R2: An accepted read is issued to memory in the same cycle to the primary copy (mem_req_mirror=0) with the requester's address. A first response without an uncorrectable flag completes on the next cycle with rsp_poison=0, the returned data, and no further memory request.
- R3: With cfg_retry_en=1, a first response flagged uncorrectable causes exactly one new memory request to the same address, one cycle after that response. No completion is returned before the retry's response.
- R4: The retry request carries mem_req_mirror equal to cfg_mirror_en. The original request always carries mem_req_mirror=0.
- R5: A retry response without an uncorrectable flag completes the read with rsp_poison=0, the retry data, and no escalation pulse.
- R6: A retry response that is flagged uncorrectable completes the read with rsp_poison=1, a one-cycle esc_pulse in the completion cycle, and esc_status set. No further memory request is made.
- R7: With cfg_retry_en=0, a flagged first response completes at once with rsp_poison=1 and escalation, and no retry request is made.
- R8: On an escalated failure, if log_valid is 0, log_addr captures the read address and log_valid is set. If log_valid is already 1, log_ovf is set and log_addr keeps its earlier value.
- R9: In a cycle with no new failure, stat_clr bits are write-one-to-clear: bit 0 clears esc_status, bit 1 clears log_valid and bit 2 clears log_ovf. Zero bits leave their status unchanged.
- R10: Only one read is outstanding. req_ready is 0 from the cycle after acceptance until the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_retry_en | input | 1 | Enables the single retry on an uncorrectable error |
| cfg_mirror_en | input | 1 | Sends the retry to the mirror copy |
| req_valid | input | 1 | Requester read request valid |
| req_ready | output | 1 | Block can accept a read |
| req_addr | input | AW | Read address |
| rsp_valid | output | 1 | Completion valid (one cycle) |
| rsp_data | output | DW | Completion data |
| rsp_poison | output | 1 | Completion data is unusable |
| mem_req_valid | output | 1 | Memory read issue strobe |
| mem_req_addr | output | AW | Memory read address |
| mem_req_mirror | output | 1 | 1 selects the mirror copy, 0 the primary |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | DW | Memory response data |
| mem_rsp_ue | input | 1 | Response carries an uncorrectable error |
| esc_pulse | output | 1 | One-cycle escalation event |
| esc_status | output | 1 | Sticky escalation status |
| stat_clr | input | 3 | Write-one-to-clear strobes for status bits |
| log_valid | output | 1 | Error log holds a captured address |
| log_ovf | output | 1 | A further failure occurred while the log was full |
| log_addr | output | AW | Captured failing address |

## Verification
The main function is exercised with four response patterns.

- A clean first response checks that no retry is issued and that the completion is not delayed.
- A flagged first response followed by a clean retry separates "retried and recovered" from "escalated", in both the primary and the mirror setting, so the routing of the retry is observed on its own.
- A flagged first response followed by a flagged retry confirms that there is only one retry and that poisoning and escalation happen together.
- A flagged response with retry disabled confirms that escalation is immediate.

The log is then driven through overflow and partial clears, to show that captured addresses are kept and that each clear bit acts alone.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE       = 2'd0,
      ST_WAIT_FIRST = 2'd1,
      ST_RETRY      = 2'd2,
      ST_WAIT_RETRY = 2'd3
   } rrt_state_e;

   localparam int CLR_W     = 3;
   localparam int CLR_ESC   = 0;
   localparam int CLR_VALID = 1;
   localparam int CLR_OVF   = 2;
endpackage

// File: rtl/rrt_ctrl.sv
module rrt_ctrl
   import rrt_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_retry_en,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic          rsp_poison,
   output logic          mem_req_valid,
   output logic [AW-1:0] mem_req_addr,
   output logic          mem_req_retry,
   input  logic          mem_rsp_valid,
   input  logic [DW-1:0] mem_rsp_data,
   input  logic          mem_rsp_ue,
   output logic          fail_now,
   output logic [AW-1:0] cur_addr
);
   rrt_state_e    state_q;
   logic [AW-1:0] addr_q;
   logic          done_first;
   logic          done_retry;

   assign cur_addr = addr_q;

   always_comb begin
      req_ready     = (state_q == ST_IDLE);
      mem_req_retry = (state_q == ST_RETRY);
      mem_req_valid = (req_ready && req_valid) || mem_req_retry;
      mem_req_addr  = req_ready ? req_addr : addr_q;
      done_first    = (state_q == ST_WAIT_FIRST) && mem_rsp_valid;
      done_retry    = (state_q == ST_WAIT_RETRY) && mem_rsp_valid;
      fail_now      = mem_rsp_ue && (done_retry || (done_first && !cfg_retry_en));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         addr_q     <= '0;
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
         rsp_poison <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  state_q <= ST_WAIT_FIRST;
               end
            end
            ST_WAIT_FIRST: begin
               if (mem_rsp_valid) begin
                  if (mem_rsp_ue && cfg_retry_en) begin
                     state_q <= ST_RETRY;
                  end else begin
                     rsp_valid  <= 1'b1;
                     rsp_data   <= mem_rsp_data;
                     rsp_poison <= mem_rsp_ue;
                     state_q    <= ST_IDLE;
                  end
               end
            end
            ST_RETRY: state_q <= ST_WAIT_RETRY;
            ST_WAIT_RETRY: begin
               if (mem_rsp_valid) begin
                  rsp_valid  <= 1'b1;
                  rsp_data   <= mem_rsp_data;
                  rsp_poison <= mem_rsp_ue;
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rrt_errlog.sv
module rrt_errlog
   import rrt_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fail_now,
   input  logic [AW-1:0]    fail_addr,
   input  logic [CLR_W-1:0] stat_clr,
   output logic             esc_pulse,
   output logic             esc_status,
   output logic             log_valid,
   output logic             log_ovf,
   output logic [AW-1:0]    log_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         esc_pulse  <= 1'b0;
         esc_status <= 1'b0;
         log_valid  <= 1'b0;
         log_ovf    <= 1'b0;
         log_addr   <= '0;
      end else begin
         esc_pulse <= fail_now;
         if (fail_now) begin
            esc_status <= 1'b1;
            if (!log_valid) begin
               log_valid <= 1'b1;
               log_addr  <= fail_addr;
            end else begin
               log_ovf <= 1'b1;
            end
         end else begin
            if (stat_clr[CLR_ESC])   esc_status <= 1'b0;
            if (stat_clr[CLR_VALID]) log_valid  <= 1'b0;
            if (stat_clr[CLR_OVF])   log_ovf    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ue_read_retry.sv
module ue_read_retry
   import rrt_pkg::*;
#(
   parameter int AW             = 16,
   parameter int DW             = 32,
   parameter bit MIRROR_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_retry_en,
   input  logic             cfg_mirror_en,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [AW-1:0]    req_addr,
   output logic             rsp_valid,
   output logic [DW-1:0]    rsp_data,
   output logic             rsp_poison,
   output logic             mem_req_valid,
   output logic [AW-1:0]    mem_req_addr,
   output logic             mem_req_mirror,
   input  logic             mem_rsp_valid,
   input  logic [DW-1:0]    mem_rsp_data,
   input  logic             mem_rsp_ue,
   output logic             esc_pulse,
   output logic             esc_status,
   input  logic [CLR_W-1:0] stat_clr,
   output logic             log_valid,
   output logic             log_ovf,
   output logic [AW-1:0]    log_addr
);
   if (AW < 1) begin : g_bad_aw
      $error("ue_read_retry: AW must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ue_read_retry: DW must be at least 1");
   end

   logic          retry_issue;
   logic          fail_now;
   logic [AW-1:0] cur_addr;

   rrt_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_retry_en (cfg_retry_en),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .rsp_poison   (rsp_poison),
      .mem_req_valid(mem_req_valid),
      .mem_req_addr (mem_req_addr),
      .mem_req_retry(retry_issue),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .mem_rsp_ue   (mem_rsp_ue),
      .fail_now     (fail_now),
      .cur_addr     (cur_addr)
   );

   if (MIRROR_SUPPORT) begin : g_mirror
      assign mem_req_mirror = retry_issue && cfg_mirror_en;
   end else begin : g_primary_only
      logic unused_mirror;
      assign unused_mirror  = cfg_mirror_en ^ retry_issue;
      assign mem_req_mirror = 1'b0;
   end

   rrt_errlog #(.AW(AW)) u_errlog (
      .clk       (clk),
      .rst_n     (rst_n),
      .fail_now  (fail_now),
      .fail_addr (cur_addr),
      .stat_clr  (stat_clr),
      .esc_pulse (esc_pulse),
      .esc_status(esc_status),
      .log_valid (log_valid),
      .log_ovf   (log_ovf),
      .log_addr  (log_addr)
   );
endmodule

// File: rtl/ue_read_retry_chk.sv
module ue_read_retry_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic          rsp_poison,
   input logic          mem_req_valid,
   input logic          mem_req_mirror,
   input logic          esc_pulse,
   input logic          esc_status,
   input logic          log_valid,
   input logic [AW-1:0] log_addr
);
   // R10
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R4
   mirror_only_on_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_mirror) |-> !req_ready);

   // R6
   poison_escalates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_poison) |-> esc_pulse);

   // R6
   esc_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esc_pulse |=> !esc_pulse);

   // R6
   esc_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esc_pulse |-> esc_status);

   // R8
   log_addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (log_valid && $past(log_valid)) |-> $stable(log_addr));
endmodule

bind ue_read_retry ue_read_retry_chk #(.AW(AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_poison    (rsp_poison),
   .mem_req_valid (mem_req_valid),
   .mem_req_mirror(mem_req_mirror),
   .esc_pulse     (esc_pulse),
   .esc_status    (esc_status),
   .log_valid     (log_valid),
   .log_addr      (log_addr)
);

// File: tb/ue_read_retry_bench.sv
`timescale 1ns/1ps
module ue_read_retry_bench;
   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_retry_en = 1'b1;
   logic          cfg_mirror_en = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          rsp_poison;
   logic          mem_req_valid;
   logic [AW-1:0] mem_req_addr;
   logic          mem_req_mirror;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rsp_data = '0;
   logic          mem_rsp_ue = 1'b0;
   logic          esc_pulse;
   logic          esc_status;
   logic [2:0]    stat_clr = 3'b000;
   logic          log_valid;
   logic          log_ovf;
   logic [AW-1:0] log_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   ue_read_retry #(.AW(AW), .DW(DW)) u_ue_read_retry (
      .clk(clk), .rst_n(rst_n), .cfg_retry_en(cfg_retry_en), .cfg_mirror_en(cfg_mirror_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_poison(rsp_poison),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_mirror(mem_req_mirror),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_ue(mem_rsp_ue),
      .esc_pulse(esc_pulse), .esc_status(esc_status), .stat_clr(stat_clr),
      .log_valid(log_valid), .log_ovf(log_ovf), .log_addr(log_addr)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Accept a read. Returns at the negedge one cycle after acceptance.
   task automatic start_read(input logic [AW-1:0] a);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      #1;
      check("R2 issue valid", 64'(mem_req_valid), 64'd1);
      check("R2 issue addr", 64'(mem_req_addr), 64'(a));
      check("R4 original primary", 64'(mem_req_mirror), 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check("R10 ready low", 64'(req_ready), 64'd0);
      check("R2 no extra issue", 64'(mem_req_valid), 64'd0);
   endtask

   // Present one memory response; returns at the following negedge.
   task automatic reply(input logic [DW-1:0] d, input logic ue);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = d;
      mem_rsp_ue    = ue;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_ue    = 1'b0;
      #1;
   endtask

   // After a flagged first response: check the retry request.
   task automatic expect_retry(input logic [AW-1:0] a, input logic mir);
      check("R3 retry issued", 64'(mem_req_valid), 64'd1);
      check("R3 retry addr", 64'(mem_req_addr), 64'(a));
      check("R4 retry mirror", 64'(mem_req_mirror), 64'(mir));
      check("R3 no early rsp", 64'(rsp_valid), 64'd0);
      check("R10 ready low retry", 64'(req_ready), 64'd0);
      @(negedge clk);
      #1;
      check("R3 single retry", 64'(mem_req_valid), 64'd0);
   endtask

   task automatic t_reset();
      check("R1 ready", 64'(req_ready), 64'd1);
      check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
      check("R1 esc_pulse", 64'(esc_pulse), 64'd0);
      check("R1 esc_status", 64'(esc_status), 64'd0);
      check("R1 log_valid", 64'(log_valid), 64'd0);
      check("R1 log_ovf", 64'(log_ovf), 64'd0);
   endtask

   task automatic t_clean();
      start_read(16'h0010);
      reply(32'hCAFE_0001, 1'b0);
      check("R2 rsp valid", 64'(rsp_valid), 64'd1);
      check("R2 rsp data", 64'(rsp_data), 64'hCAFE_0001);
      check("R2 rsp poison", 64'(rsp_poison), 64'd0);
      check("R2 no esc", 64'(esc_pulse), 64'd0);
      check("R2 no retry", 64'(mem_req_valid), 64'd0);
      check("R10 ready back", 64'(req_ready), 64'd1);
   endtask

   task automatic t_retry_ok(input logic mir, input logic [AW-1:0] a);
      cfg_mirror_en = mir;
      start_read(a);
      reply(32'hBAD0_0000, 1'b1);
      expect_retry(a, mir);
      reply(32'h600D_0000 | 32'(a), 1'b0);
      check("R5 rsp valid", 64'(rsp_valid), 64'd1);
      check("R5 rsp data", 64'(rsp_data), 64'(32'h600D_0000 | 32'(a)));
      check("R5 rsp poison", 64'(rsp_poison), 64'd0);
      check("R5 no esc", 64'(esc_pulse), 64'd0);
      check("R5 no status", 64'(esc_status), 64'd0);
      check("R5 no log", 64'(log_valid), 64'd0);
   endtask

   task automatic t_double_fail();
      cfg_mirror_en = 1'b1;
      start_read(16'h0ABC);
      reply(32'h1111_1111, 1'b1);
      expect_retry(16'h0ABC, 1'b1);
      reply(32'h2222_2222, 1'b1);
      check("R6 rsp valid", 64'(rsp_valid), 64'd1);
      check("R6 rsp poison", 64'(rsp_poison), 64'd1);
      check("R6 esc pulse", 64'(esc_pulse), 64'd1);
      check("R6 esc status", 64'(esc_status), 64'd1);
      check("R8 log valid", 64'(log_valid), 64'd1);
      check("R8 log addr", 64'(log_addr), 64'h0ABC);
      check("R8 no ovf", 64'(log_ovf), 64'd0);
      @(negedge clk);
      #1;
      check("R6 pulse ends", 64'(esc_pulse), 64'd0);
      check("R6 no 2nd retry", 64'(mem_req_valid), 64'd0);
      check("R6 status sticky", 64'(esc_status), 64'd1);
   endtask

   task automatic t_disabled();
      cfg_retry_en = 1'b0;
      start_read(16'h0777);
      reply(32'h3333_3333, 1'b1);
      check("R7 rsp valid", 64'(rsp_valid), 64'd1);
      check("R7 rsp poison", 64'(rsp_poison), 64'd1);
      check("R7 esc pulse", 64'(esc_pulse), 64'd1);
      check("R7 no retry", 64'(mem_req_valid), 64'd0);
      check("R8 ovf set", 64'(log_ovf), 64'd1);
      check("R8 addr kept", 64'(log_addr), 64'h0ABC);
      cfg_retry_en = 1'b1;
   endtask

   task automatic pulse_clr(input logic [2:0] v);
      stat_clr = v;
      @(negedge clk);
      stat_clr = 3'b000;
      #1;
   endtask

   task automatic t_clear();
      pulse_clr(3'b000);
      check("R9 zero no effect esc", 64'(esc_status), 64'd1);
      check("R9 zero no effect valid", 64'(log_valid), 64'd1);
      check("R9 zero no effect ovf", 64'(log_ovf), 64'd1);
      pulse_clr(3'b001);
      check("R9 esc cleared", 64'(esc_status), 64'd0);
      check("R9 valid kept", 64'(log_valid), 64'd1);
      check("R9 ovf kept", 64'(log_ovf), 64'd1);
      pulse_clr(3'b110);
      check("R9 valid cleared", 64'(log_valid), 64'd0);
      check("R9 ovf cleared", 64'(log_ovf), 64'd0);
      cfg_retry_en = 1'b0;
      start_read(16'h0042);
      reply(32'h4444_4444, 1'b1);
      check("R8 recapture addr", 64'(log_addr), 64'h0042);
      check("R8 recapture valid", 64'(log_valid), 64'd1);
      check("R8 recapture no ovf", 64'(log_ovf), 64'd0);
      cfg_retry_en = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_clean();
      t_retry_ok(1'b0, 16'h0123);
      t_retry_ok(1'b1, 16'h0456);
      t_double_fail();
      t_disabled();
      t_clear();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule